// File: doc/BRIEF.md
# Grouped Priority Interrupt Resolver

This block takes a vector of pending exception requests, an enable mask and one 8-bit priority per exception. Each clock it picks a single winner among the requests that are both pending and enabled. A 3-bit grouping control divides every programmable priority at a chosen bit. The upper bits form the preemption group and the lower bits form a sub-priority. The candidate with the numerically lowest group wins. If groups are equal, the lowest sub-priority wins. If both are still equal, the lowest exception number wins.

Exceptions 1, 2 and 3 do not use their priority inputs. They carry fixed levels that are more urgent than any programmable level: exception 1 is the most urgent, then exception 2, then exception 3. Exception number 0 means "no exception" and can never win. The outputs are registered and hold the winning number, a valid flag and the winner's group priority. A downstream preemption stage compares that group priority against the priority of the running handler.

Top module: `prio_resolver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, winValid, winNum and winGroup are all 0.
- R2: When no exception numbered 1 or higher is both pending and enabled, the next registered result has winValid = 0, winNum = 0 and winGroup = 0.
- R3: The result reflects the inputs present at the previous rising clock edge. A change on the inputs leaves the outputs unchanged until the next rising edge.
- R4: Among candidates, the one whose group part (priority bits [7:g+1]) has the lowest value wins. Here g is the value on groupSel.
- R5: Among candidates with equal group parts, the one whose sub-priority (priority bits [g:0]) is lowest wins.
- R6: Among candidates with equal group part and equal sub-priority, the lowest exception number wins.
- R7: For a programmable winner, winGroup is {1'b0, prio} with bits [g:0] cleared. With g = 7 every programmable winner reports winGroup = 0.
- R8: Exceptions 1, 2 and 3 ignore their priority inputs. They rank as the signed 9-bit levels -3, -2 and -1, which are 9'h1FD, 9'h1FE and 9'h1FF. They beat every programmable level, and winGroup reports that 9-bit value.
- R9: A request counts only if both its pend bit and its en bit are set, and bit 0 of both vectors is ignored. A winning number always refers to such a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pendVec | input | NUM_EXC | Pending flag per exception number |
| enVec | input | NUM_EXC | Enable flag per exception number |
| prioFlat | input | NUM_EXC*8 | Priority of exception i in bits [8i+7:8i] |
| groupSel | input | 3 | Split point g: group = bits [7:g+1], sub = bits [g:0] |
| winValid | output | 1 | A winner exists |
| winNum | output | $clog2(NUM_EXC) | Winning exception number, 0 when none |
| winGroup | output | 9 | Signed group priority of the winner, 0 when none |

## Verification
Two decisions can land in the same cycle: the sub-priority comparison and the exception-number tie-break. The fixed levels of exceptions 1 to 3 can also compete with programmable requests at group 0. The bench provokes these collisions by drawing priorities from a narrow value set, so that equal groups and equal sub-priorities occur often under every groupSel setting. It judges each result against an integer ranking computed in the bench, in which fixed entries take negative ranks and ties fall to the lower index.

// File: rtl/resolver_pkg.sv
package resolver_pkg;
  localparam int PRIO_W  = 8;
  localparam int GROUP_W = PRIO_W + 1;
  localparam int FIXED_N = 3;

  typedef struct packed {
    logic [PRIO_W-1:0] subMask;   // ones over the sub-priority bits
    logic              clearWin;  // no candidate: drive idle result
  } ctrlStrobes_t;
endpackage

// File: rtl/resolver_ctrl.sv
module resolver_ctrl
  import resolver_pkg::*;
(
  input  logic [2:0]   groupSel,
  input  logic         anyReq,
  output ctrlStrobes_t strobes
);
  logic [PRIO_W:0] maskWide;

  always_comb begin
    maskWide         = ((PRIO_W+1)'(2) << groupSel) - (PRIO_W+1)'(1);
    strobes.subMask  = maskWide[PRIO_W-1:0];
    strobes.clearWin = !anyReq;
  end
endmodule

// File: rtl/resolver_datapath.sv
module resolver_datapath
  import resolver_pkg::*;
#(
  parameter int NUM_EXC = 32,
  parameter int NUM_W   = $clog2(NUM_EXC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EXC-1:0]        pendVec,
  input  logic [NUM_EXC-1:0]        enVec,
  input  logic [NUM_EXC*PRIO_W-1:0] prioFlat,
  input  ctrlStrobes_t              strobes,
  output logic                      anyReq,
  output logic                      winValid,
  output logic [NUM_W-1:0]          winNum,
  output logic [GROUP_W-1:0]        winGroup
);
  localparam int KEY_W = GROUP_W + PRIO_W;

  logic [NUM_EXC-1:0]   reqVec;
  logic [GROUP_W-1:0]   candGroup [NUM_EXC];
  logic [PRIO_W-1:0]    candSub   [NUM_EXC];
  logic [KEY_W-1:0]     candKey   [NUM_EXC];
  logic [KEY_W-1:0]     bestKey;
  logic [NUM_W-1:0]     bestNum;
  logic [GROUP_W-1:0]   bestGroup;
  logic                 bestFound;

  assign reqVec = pendVec & enVec & ~NUM_EXC'(1);
  assign anyReq = |reqVec;

  // Per-exception ranking key; sign bit flipped so an unsigned compare orders it.
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_key
    logic [PRIO_W-1:0] prioVal;
    assign prioVal = prioFlat[i*PRIO_W +: PRIO_W];
    if (i >= 1 && i <= FIXED_N) begin : g_fixed
      assign candGroup[i] = GROUP_W'(i) - GROUP_W'(FIXED_N + 1);
      assign candSub[i]   = '0;
    end else begin : g_prog
      assign candGroup[i] = {1'b0, prioVal & ~strobes.subMask};
      assign candSub[i]   = prioVal & strobes.subMask;
    end
    assign candKey[i] = {~candGroup[i][GROUP_W-1], candGroup[i][GROUP_W-2:0], candSub[i]};
  end

  // Ascending scan: only a strictly better key replaces, so lower numbers keep ties.
  always_comb begin
    bestFound = 1'b0;
    bestKey   = '1;
    bestNum   = '0;
    bestGroup = '0;
    for (int i = 1; i < NUM_EXC; i++) begin
      if (reqVec[i] && (!bestFound || candKey[i] < bestKey)) begin
        bestFound = 1'b1;
        bestKey   = candKey[i];
        bestNum   = NUM_W'(i);
        bestGroup = candGroup[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winValid <= 1'b0;
      winNum   <= '0;
      winGroup <= '0;
    end else if (strobes.clearWin) begin
      winValid <= 1'b0;
      winNum   <= '0;
      winGroup <= '0;
    end else begin
      winValid <= 1'b1;
      winNum   <= bestNum;
      winGroup <= bestGroup;
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import resolver_pkg::*;
#(
  parameter int NUM_EXC = 32,
  localparam int NUM_W  = $clog2(NUM_EXC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EXC-1:0]        pendVec,
  input  logic [NUM_EXC-1:0]        enVec,
  input  logic [NUM_EXC*PRIO_W-1:0] prioFlat,
  input  logic [2:0]                groupSel,
  output logic                      winValid,
  output logic [NUM_W-1:0]          winNum,
  output logic [GROUP_W-1:0]        winGroup
);
  ctrlStrobes_t strobes;
  logic         anyReq;

  resolver_ctrl u_ctrl (
    .groupSel (groupSel),
    .anyReq   (anyReq),
    .strobes  (strobes)
  );

  resolver_datapath #(.NUM_EXC(NUM_EXC), .NUM_W(NUM_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pendVec  (pendVec),
    .enVec    (enVec),
    .prioFlat (prioFlat),
    .strobes  (strobes),
    .anyReq   (anyReq),
    .winValid (winValid),
    .winNum   (winNum),
    .winGroup (winGroup)
  );
endmodule

// File: rtl/prio_resolver_checker.sv
module prio_resolver_checker #(
  parameter int NUM_EXC = 32,
  localparam int NUM_W  = $clog2(NUM_EXC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EXC-1:0] pendVec,
  input logic [NUM_EXC-1:0] enVec,
  input logic               winValid,
  input logic [NUM_W-1:0]   winNum,
  input logic [8:0]         winGroup
);
  logic primed;
  logic [NUM_EXC-1:0] liveReq;

  assign liveReq = pendVec & enVec & ~NUM_EXC'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  p_valid_tracks_req_r2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    winValid == $past(|liveReq));

  p_idle_outputs_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !winValid |-> (winNum == '0 && winGroup == '0));

  p_winner_was_request_r9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    winValid |-> ((($past(liveReq) >> winNum) & NUM_EXC'(1)) != '0));

  p_never_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    winValid |-> winNum != '0);

  p_fixed_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (winValid && winNum >= NUM_W'(1) && winNum <= NUM_W'(3)) |->
      winGroup == 9'h1FC + 9'(winNum));

  p_fixed_beats_prog_r8: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(liveReq[1] | liveReq[2] | liveReq[3])) |-> (winNum <= NUM_W'(3) && winGroup[8]));

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (!winValid && winNum == '0 && winGroup == '0));
endmodule

bind prio_resolver prio_resolver_checker #(.NUM_EXC(NUM_EXC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pendVec  (pendVec),
  .enVec    (enVec),
  .winValid (winValid),
  .winNum   (winNum),
  .winGroup (winGroup)
);

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int NW = $clog2(N);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pendVec = '0;
  logic [N-1:0]   enVec = '0;
  logic [N*8-1:0] prioFlat = '0;
  logic [2:0]     groupSel = '0;
  logic           winValid;
  logic [NW-1:0]  winNum;
  logic [8:0]     winGroup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_resolver #(.NUM_EXC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .enVec(enVec),
    .prioFlat(prioFlat), .groupSel(groupSel),
    .winValid(winValid), .winNum(winNum), .winGroup(winGroup)
  );

  task automatic check(input string tag, input logic v, input int n, input int g,
                       input logic ev, input int en, input int eg);
    checks++;
    if (winValid !== ev || int'(winNum) != en || int'(winGroup) != eg) begin
      errors++;
      $display("FAIL %s: got valid=%0b num=%0d group=%03h, expected valid=%0b num=%0d group=%03h",
               tag, v, n, g, ev, en, eg);
    end
  endtask

  task automatic setPrio(input int idx, input logic [7:0] p);
    prioFlat[idx*8 +: 8] = p;
  endtask

  // Arithmetic reference: integer rank, fixed entries negative, ties to lower index.
  task automatic expectOf(output logic ev, output int en, output int eg);
    int bestRank;
    int g;
    g = int'(groupSel);
    ev = 1'b0; en = 0; eg = 0; bestRank = 1 << 30;
    for (int i = 1; i < N; i++) begin
      if (pendVec[i] && enVec[i]) begin
        int p;
        int rank;
        int grp;
        p = int'(prioFlat[i*8 +: 8]);
        if (i <= 3) begin
          rank = i - 4;
          grp  = 'h1FC + i;
        end else begin
          rank = (p >> (g + 1)) * 512 + (p % (1 << (g + 1)));
          grp  = (p >> (g + 1)) << (g + 1);
        end
        if (rank < bestRank) begin
          bestRank = rank; ev = 1'b1; en = i; eg = grp;
        end
      end
    end
  endtask

  task automatic stepAndCheck(input string tag);
    logic ev;
    int en;
    int eg;
    expectOf(ev, en, eg);
    @(posedge clk);
    @(negedge clk);
    check(tag, winValid, int'(winNum), int'(winGroup), ev, en, eg);
  endtask

  function automatic logic [31:0] nextRng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, and first cycle after release
    repeat (3) @(negedge clk);
    check("R1 in reset", winValid, int'(winNum), int'(winGroup), 1'b0, 0, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after release", winValid, int'(winNum), int'(winGroup), 1'b0, 0, 0);

    // R2: pending but nothing enabled
    pendVec = '1; enVec = '0;
    stepAndCheck("R2 none enabled");
    // R9: only bit 0 pending and enabled is ignored
    pendVec = 16'h0001; enVec = 16'h0001;
    stepAndCheck("R9 bit0 ignored");
    // R9: urgent but disabled request loses to enabled one
    pendVec = 16'h0030; enVec = 16'h0020;
    setPrio(4, 8'h00); setPrio(5, 8'hF0); groupSel = 3'd0;
    stepAndCheck("R9 disabled loses");

    // R4: lower group wins
    pendVec = 16'h0030; enVec = '1;
    setPrio(4, 8'h80); setPrio(5, 8'h40);
    stepAndCheck("R4 lower group");
    // R5: same group, lower sub wins (g=3)
    groupSel = 3'd3; pendVec = 16'h0050;
    setPrio(4, 8'h1F); setPrio(6, 8'h13);
    stepAndCheck("R5 lower sub");
    // R6: identical priority, lower number wins
    pendVec = 16'h0280; setPrio(7, 8'h22); setPrio(9, 8'h22);
    stepAndCheck("R6 lower number");
    // R7: g=7 puts everything in sub; group output 0
    groupSel = 3'd7; pendVec = 16'h0410;
    setPrio(4, 8'hF0); setPrio(10, 8'h05);
    stepAndCheck("R7 all sub");
    // R8: fixed entry ignores its priority input and beats priority 0
    groupSel = 3'd0; pendVec = 16'h0018;
    setPrio(3, 8'hFF); setPrio(4, 8'h00);
    stepAndCheck("R8 fixed beats zero");
    pendVec = 16'h000E;
    stepAndCheck("R8 fixed order");

    // R3: input change not visible before the next edge
    pendVec = 16'h0010;
    #1;
    check("R3 held before edge", winValid, int'(winNum), int'(winGroup), 1'b1, 1, 'h1FD);
    stepAndCheck("R3 after edge");

    // R4 R5 R6 R7 R8: sweep over every split with clustered priorities
    for (int g = 0; g < 8; g++) begin
      groupSel = 3'(g);
      for (int t = 0; t < 60; t++) begin
        rng = nextRng(rng); pendVec = rng[15:0]; enVec = rng[31:16] | 16'hC3F0;
        for (int i = 0; i < N; i++) begin
          rng = nextRng(rng);
          setPrio(i, {rng[2:0], 2'b00, rng[5:3]});
        end
        stepAndCheck("R7 sweep");
      end
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule